// File: doc/BRIEF.md
# Dual-Port Collision Busy Arbiter

This block sits between the two ports of a shared memory and resolves access collisions. Each cycle it compares the left and right chip enables and addresses. When both ports select the same word, one access proceeds and the other port sees an active-low busy line. The block also suppresses the losing port's write strobe toward the memory array, so that write never lands. Only enables and addresses take part in the decision. The read/write direction plays no role in the arbitration.

A mode input selects master or slave behaviour. A master arbitrates, drives its busy lines and raises their output enables. A slave stops arbitrating and releases its busy lines. It then samples them as write-inhibit inputs, so a wide memory built from several arrays can share one master's decision. A combined active-low flag reports busy on either line and can serve as an error interrupt. The memory array itself lies outside this block.

Top module: `dp_collision_arbiter`

## Requirements
- R1: A collision exists only when both ports are enabled and their addresses are equal. In master mode with no collision in the current cycle or the previous one, both busy lines stay high.
- R2: When a collision starts and neither port, or both ports, held that address in the previous cycle, the left port wins (default tie setting). The right busy line goes low in the same cycle.
- R3: When one port was already enabled at the colliding address in the previous cycle and the other was not, the port that held the address wins. The newcomer's busy line goes low in the same cycle.
- R4: The winner keeps priority for as long as it stays enabled at that address. Once the collision ends, the loser's busy line stays low for the rest of that cycle and returns high in the following cycle.
- R5: In master mode, a port's memory write strobe equals enable AND write request AND NOT busy. A busy port never writes.
- R6: Changing either port's write request does not alter which port receives busy.
- R7: In slave mode, both busy output enables are low, no arbitration takes place, and each port's write strobe equals enable AND write request AND its busy input. A high busy input allows writes and a low one blocks them. In master mode the busy inputs are ignored and both output enables are high.
- R8: The combined flag is the AND of the two active-low busy line levels. These are the driven values in master mode and the busy inputs in slave mode.
- R9: Reset clears the arbitration history. In the first cycle after reset, both ports are treated as newcomers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| master_mode | input | 1 | 1 selects master (arbitrate, drive busy), 0 selects slave |
| l_en | input | 1 | Left port chip enable, active high |
| l_wr | input | 1 | Left port write request |
| l_addr | input | ADDR_W | Left port address |
| r_en | input | 1 | Right port chip enable, active high |
| r_wr | input | 1 | Right port write request |
| r_addr | input | ADDR_W | Right port address |
| l_busy_n_i | input | 1 | Left busy line as seen at the pin (write inhibit in slave mode) |
| r_busy_n_i | input | 1 | Right busy line as seen at the pin (write inhibit in slave mode) |
| l_busy_n_o | output | 1 | Left busy line drive value, active low |
| l_busy_oe | output | 1 | Left busy line output enable |
| r_busy_n_o | output | 1 | Right busy line drive value, active low |
| r_busy_oe | output | 1 | Right busy line output enable |
| l_mem_we | output | 1 | Gated left write strobe to the memory |
| r_mem_we | output | 1 | Gated right write strobe to the memory |
| any_busy_n | output | 1 | Combined busy flag, active low |

## Verification
Busy lines, write strobes, output enables and the combined flag are combinational in the current inputs. Each of these results is due in the same cycle as the stimulus that causes it. The arbitration history (who held an address, who won) advances on each rising edge, so R3, R4 and R9 outcomes are due one clock after the input that sets them up, and R4's release shows up exactly one cycle after the collision ends. The bench changes inputs on the falling edge and samples a quarter period later, before the next rising edge. Each vector therefore sees the history built by the vectors before it, and the release vector and the one after it check both sides of that single cycle.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_e;

   localparam int NUM_PORTS = 2;
   localparam int PORT_L    = 0;
   localparam int PORT_R    = 1;

endpackage

// File: rtl/dpa_hit_detect.sv
module dpa_hit_detect #(
   parameter int ADDR_W = 13
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_en,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              r_en,
   input  logic [ADDR_W-1:0] r_addr,
   output logic              hit,
   output logic              l_held,
   output logic              r_held
);

   if (ADDR_W < 1) begin : g_bad_width
      $error("dpa_hit_detect: ADDR_W must be at least 1");
   end

   logic              l_en_q;
   logic              r_en_q;
   logic [ADDR_W-1:0] l_addr_q;
   logic [ADDR_W-1:0] r_addr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         l_en_q   <= 1'b0;
         r_en_q   <= 1'b0;
         l_addr_q <= '0;
         r_addr_q <= '0;
      end else begin
         l_en_q   <= l_en;
         r_en_q   <= r_en;
         l_addr_q <= l_addr;
         r_addr_q <= r_addr;
      end
   end

   always_comb begin
      hit    = l_en && r_en && (l_addr == r_addr);
      l_held = l_en && l_en_q && (l_addr == l_addr_q);
      r_held = r_en && r_en_q && (r_addr == r_addr_q);
   end

endmodule

// File: rtl/dpa_owner_fsm.sv
module dpa_owner_fsm
   import dpa_pkg::*;
#(
   parameter bit TIE_TO_LEFT = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic master,
   input  logic hit,
   input  logic l_held,
   input  logic r_held,
   output logic busy_l,
   output logic busy_r
);

   owner_e owner_q;
   owner_e cur;
   owner_e tie_owner;

   if (TIE_TO_LEFT) begin : g_tie_left
      assign tie_owner = OWN_LEFT;
   end else begin : g_tie_right
      assign tie_owner = OWN_RIGHT;
   end

   always_comb begin
      if (!master || !hit) begin
         cur = OWN_NONE;
      end else if (owner_q == OWN_LEFT && l_held) begin
         cur = OWN_LEFT;
      end else if (owner_q == OWN_RIGHT && r_held) begin
         cur = OWN_RIGHT;
      end else if (l_held && !r_held) begin
         cur = OWN_LEFT;
      end else if (r_held && !l_held) begin
         cur = OWN_RIGHT;
      end else begin
         cur = tie_owner;
      end
   end

   always_comb begin
      busy_l = (cur == OWN_RIGHT) || (master && !hit && owner_q == OWN_RIGHT);
      busy_r = (cur == OWN_LEFT)  || (master && !hit && owner_q == OWN_LEFT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         owner_q <= OWN_NONE;
      end else begin
         owner_q <= cur;
      end
   end

   AST_BUSY_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy_l && busy_r)); // R2

   AST_QUIET_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !$past(hit)) |-> (!busy_l && !busy_r)); // R1

   AST_RELEASE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (master && !hit) |=> (hit || !master || (!busy_l && !busy_r))); // R4

   AST_WINNER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (master && hit && l_held && r_held && $past(busy_r)) |-> busy_r); // R4

endmodule

// File: rtl/dpa_port_gate.sv
module dpa_port_gate (
   input  logic master,
   input  logic en,
   input  logic wr,
   input  logic busy_int,
   input  logic busy_n_in,
   output logic busy_n_out,
   output logic busy_oe,
   output logic pin_level_n,
   output logic mem_we
);

   logic inhibit;

   always_comb begin
      busy_oe     = master;
      busy_n_out  = master ? !busy_int : 1'b1;
      pin_level_n = master ? busy_n_out : busy_n_in;
      inhibit     = master ? busy_int : !busy_n_in;
      mem_we      = en && wr && !inhibit;
   end

endmodule

// File: rtl/dp_collision_arbiter.sv
module dp_collision_arbiter
   import dpa_pkg::*;
#(
   parameter int ADDR_W      = 13,
   parameter bit TIE_TO_LEFT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              master_mode,
   input  logic              l_en,
   input  logic              l_wr,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic              r_en,
   input  logic              r_wr,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic              l_busy_n_i,
   input  logic              r_busy_n_i,
   output logic              l_busy_n_o,
   output logic              l_busy_oe,
   output logic              r_busy_n_o,
   output logic              r_busy_oe,
   output logic              l_mem_we,
   output logic              r_mem_we,
   output logic              any_busy_n
);

   if (ADDR_W < 1 || ADDR_W > 32) begin : g_bad_addr
      $error("dp_collision_arbiter: ADDR_W out of range 1..32");
   end

   logic hit;
   logic l_held;
   logic r_held;
   logic busy_l;
   logic busy_r;

   logic [NUM_PORTS-1:0] p_en;
   logic [NUM_PORTS-1:0] p_wr;
   logic [NUM_PORTS-1:0] p_busy;
   logic [NUM_PORTS-1:0] p_bin;
   logic [NUM_PORTS-1:0] p_bout;
   logic [NUM_PORTS-1:0] p_oe;
   logic [NUM_PORTS-1:0] p_lvl;
   logic [NUM_PORTS-1:0] p_we;

   dpa_hit_detect #(
      .ADDR_W (ADDR_W)
   ) u_hit (
      .clk    (clk),
      .rst_n  (rst_n),
      .l_en   (l_en),
      .l_addr (l_addr),
      .r_en   (r_en),
      .r_addr (r_addr),
      .hit    (hit),
      .l_held (l_held),
      .r_held (r_held)
   );

   dpa_owner_fsm #(
      .TIE_TO_LEFT (TIE_TO_LEFT)
   ) u_owner (
      .clk    (clk),
      .rst_n  (rst_n),
      .master (master_mode),
      .hit    (hit),
      .l_held (l_held),
      .r_held (r_held),
      .busy_l (busy_l),
      .busy_r (busy_r)
   );

   assign p_en[PORT_L]   = l_en;
   assign p_en[PORT_R]   = r_en;
   assign p_wr[PORT_L]   = l_wr;
   assign p_wr[PORT_R]   = r_wr;
   assign p_busy[PORT_L] = busy_l;
   assign p_busy[PORT_R] = busy_r;
   assign p_bin[PORT_L]  = l_busy_n_i;
   assign p_bin[PORT_R]  = r_busy_n_i;

   for (genvar gi = 0; gi < NUM_PORTS; gi++) begin : g_port
      dpa_port_gate u_gate (
         .master      (master_mode),
         .en          (p_en[gi]),
         .wr          (p_wr[gi]),
         .busy_int    (p_busy[gi]),
         .busy_n_in   (p_bin[gi]),
         .busy_n_out  (p_bout[gi]),
         .busy_oe     (p_oe[gi]),
         .pin_level_n (p_lvl[gi]),
         .mem_we      (p_we[gi])
      );
   end

   assign l_busy_n_o = p_bout[PORT_L];
   assign r_busy_n_o = p_bout[PORT_R];
   assign l_busy_oe  = p_oe[PORT_L];
   assign r_busy_oe  = p_oe[PORT_R];
   assign l_mem_we   = p_we[PORT_L];
   assign r_mem_we   = p_we[PORT_R];
   assign any_busy_n = &p_lvl;

   AST_LEFT_LOSER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && !l_busy_n_o) |-> !l_mem_we); // R5

   AST_RIGHT_LOSER_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && !r_busy_n_o) |-> !r_mem_we); // R5

   AST_SLAVE_RELEASES_LINES: assert property (@(posedge clk) disable iff (!rst_n)
      !master_mode |-> (!l_busy_oe && !r_busy_oe && l_busy_n_o && r_busy_n_o)); // R7

   AST_FLAG_LOW_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (master_mode && !(l_busy_n_o && r_busy_n_o)) |-> !any_busy_n); // R8

endmodule

// File: tb/dp_collision_arbiter_bench.sv
module dp_collision_arbiter_bench;

   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 13;
   localparam int NV         = 18;

   typedef struct packed {
      logic [3:0] req;
      logic       ms;
      logic       len;
      logic [7:0] la;
      logic       lw;
      logic       ren;
      logic [7:0] ra;
      logic       rw;
      logic       lbi;
      logic       rbi;
      logic [4:0] exp;   // {l_busy_n, r_busy_n, l_we, r_we, any_busy_n}
   } vec_t;

   localparam vec_t VECS [0:NV-1] = '{
      '{4'd9, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 5'b11001}, // R9 idle after reset
      '{4'd1, 1'b1, 1'b1, 8'h05, 1'b1, 1'b1, 8'h06, 1'b1, 1'b1, 1'b1, 5'b11111}, // R1 different addresses
      '{4'd1, 1'b1, 1'b1, 8'h07, 1'b1, 1'b0, 8'h07, 1'b1, 1'b1, 1'b1, 5'b11101}, // R1 same address, right off
      '{4'd1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 5'b11001}, // R1 idle
      '{4'd2, 1'b1, 1'b1, 8'h05, 1'b1, 1'b1, 8'h05, 1'b1, 1'b1, 1'b1, 5'b10100}, // R2 tie goes left
      '{4'd4, 1'b1, 1'b1, 8'h05, 1'b1, 1'b1, 8'h05, 1'b1, 1'b1, 1'b1, 5'b10100}, // R4 win held
      '{4'd4, 1'b1, 1'b0, 8'h05, 1'b1, 1'b1, 8'h05, 1'b1, 1'b1, 1'b1, 5'b10000}, // R4 busy held one cycle
      '{4'd4, 1'b1, 1'b0, 8'h05, 1'b1, 1'b1, 8'h05, 1'b1, 1'b1, 1'b1, 5'b11011}, // R4 released
      '{4'd3, 1'b1, 1'b1, 8'h05, 1'b0, 1'b1, 8'h05, 1'b1, 1'b1, 1'b1, 5'b01010}, // R3 right held, left read loses
      '{4'd5, 1'b1, 1'b1, 8'h05, 1'b1, 1'b1, 8'h05, 1'b1, 1'b1, 1'b1, 5'b01010}, // R5 loser write gated
      '{4'd4, 1'b1, 1'b1, 8'h05, 1'b1, 1'b1, 8'h09, 1'b1, 1'b1, 1'b1, 5'b01010}, // R4 winner moved, held one cycle
      '{4'd4, 1'b1, 1'b1, 8'h05, 1'b1, 1'b1, 8'h09, 1'b1, 1'b1, 1'b1, 5'b11111}, // R4 released
      '{4'd6, 1'b1, 1'b1, 8'h05, 1'b1, 1'b1, 8'h05, 1'b0, 1'b1, 1'b1, 5'b10100}, // R6 right read still loses
      '{4'd6, 1'b1, 1'b1, 8'h07, 1'b0, 1'b1, 8'h07, 1'b1, 1'b1, 1'b1, 5'b10000}, // R6 both move, tie left though left reads
      '{4'd7, 1'b0, 1'b1, 8'h05, 1'b1, 1'b1, 8'h05, 1'b1, 1'b1, 1'b1, 5'b11111}, // R7 slave ignores collision
      '{4'd8, 1'b0, 1'b1, 8'h05, 1'b1, 1'b1, 8'h05, 1'b1, 1'b0, 1'b1, 5'b11010}, // R8 left inhibit, flag low
      '{4'd7, 1'b0, 1'b1, 8'h05, 1'b1, 1'b1, 8'h02, 1'b1, 1'b1, 1'b0, 5'b11100}, // R7 right inhibit
      '{4'd7, 1'b1, 1'b1, 8'h04, 1'b1, 1'b1, 8'h08, 1'b1, 1'b0, 1'b0, 5'b11111}  // R7 master ignores inputs
   };

   logic              clk;
   logic              rst_n;
   logic              master_mode;
   logic              l_en;
   logic              l_wr;
   logic [ADDR_W-1:0] l_addr;
   logic              r_en;
   logic              r_wr;
   logic [ADDR_W-1:0] r_addr;
   logic              l_busy_n_i;
   logic              r_busy_n_i;
   logic              l_busy_n_o;
   logic              l_busy_oe;
   logic              r_busy_n_o;
   logic              r_busy_oe;
   logic              l_mem_we;
   logic              r_mem_we;
   logic              any_busy_n;

   int checks;
   int errors;
   bit done;

   dp_collision_arbiter #(
      .ADDR_W (ADDR_W)
   ) u_dp_collision_arbiter (
      .clk         (clk),
      .rst_n       (rst_n),
      .master_mode (master_mode),
      .l_en        (l_en),
      .l_wr        (l_wr),
      .l_addr      (l_addr),
      .r_en        (r_en),
      .r_wr        (r_wr),
      .r_addr      (r_addr),
      .l_busy_n_i  (l_busy_n_i),
      .r_busy_n_i  (r_busy_n_i),
      .l_busy_n_o  (l_busy_n_o),
      .l_busy_oe   (l_busy_oe),
      .r_busy_n_o  (r_busy_n_o),
      .r_busy_oe   (r_busy_oe),
      .l_mem_we    (l_mem_we),
      .r_mem_we    (r_mem_we),
      .any_busy_n  (any_busy_n)
   );

   initial clk = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   function automatic logic [4:0] outs();
      return {l_busy_n_o, r_busy_n_o, l_mem_we, r_mem_we, any_busy_n};
   endfunction

   task automatic check5(input string tag, input logic [4:0] act, input logic [4:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic drive(input vec_t v);
      master_mode = v.ms;
      l_en        = v.len;
      l_addr      = {{(ADDR_W-8){1'b0}}, v.la};
      l_wr        = v.lw;
      r_en        = v.ren;
      r_addr      = {{(ADDR_W-8){1'b0}}, v.ra};
      r_wr        = v.rw;
      l_busy_n_i  = v.lbi;
      r_busy_n_i  = v.rbi;
   endtask

   initial begin
      #(CLK_PERIOD * 2000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      checks = 0;
      errors = 0;
      done   = 1'b0;
      rst_n  = 1'b0;
      drive('{4'd0, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 5'b0});
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // vector table, one vector per cycle
      for (int i = 0; i < NV; i++) begin
         drive(VECS[i]);
         #(CLK_PERIOD / 4);
         check5($sformatf("R%0d vec %0d", VECS[i].req, i), outs(), VECS[i].exp);
         @(negedge clk);
      end

      // R7: output enables high in master mode
      drive('{4'd7, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 5'b0});
      #(CLK_PERIOD / 4);
      check5("R7 oe master", {3'b000, l_busy_oe, r_busy_oe}, 5'b00011);
      @(negedge clk);
      master_mode = 1'b0;
      #(CLK_PERIOD / 4);
      check5("R7 oe slave", {3'b000, l_busy_oe, r_busy_oe}, 5'b00000);
      @(negedge clk);

      // R3 then R9: right holds address 1, left arrives and loses; reset clears history
      drive('{4'd3, 1'b1, 1'b0, 8'h00, 1'b1, 1'b1, 8'h01, 1'b1, 1'b1, 1'b1, 5'b0});
      @(negedge clk);
      @(negedge clk);
      l_en   = 1'b1;
      l_addr = {{(ADDR_W-8){1'b0}}, 8'h01};
      #(CLK_PERIOD / 4);
      check5("R3 late left loses", outs(), 5'b01010);
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #(CLK_PERIOD / 4);
      check5("R9 history cleared, tie left", outs(), 5'b10100);
      @(negedge clk);

      // R1: idle after everything
      drive('{4'd1, 1'b1, 1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 5'b0});
      @(negedge clk);
      #(CLK_PERIOD / 4);
      check5("R1 final idle", outs(), 5'b11001);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule